// File: doc/BRIEF.md
# QPSK Byte-to-Symbol Mapper

This block turns a stream of 8-bit bytes into QPSK baseband symbols. A producer offers bytes over a valid/ready handshake; each accepted byte is cut into four 2-bit pairs, and each pair is turned into one signed I/Q sample pair. The samples are 8-bit two's complement words that can drive a DAC directly. Each rail swings to plus or minus a fixed full-scale amplitude, 127 by default.

Symbols leave at a fixed pace. An internal divider spaces them `SYM_DIV` clocks apart, and each symbol is marked by a single-cycle `out_valid` strobe. The block asks for the next byte while it launches the last pair of the current byte. A steady producer therefore gets an unbroken symbol stream with no idle slot at byte boundaries. Pulse shaping, interpolation and carrier mixing belong to later blocks.

Top module: `qpsk_pair_mapper`

## Requirements
- R1: The pairs of a byte are sent most significant first: bits 7:6, then 5:4, then 3:2, then 1:0.
- R2: In a pair, the upper bit sets the sign of I and the lower bit sets the sign of Q (0 gives +AMP, 1 gives -AMP). With the default AMP=127 the output levels are 0x7F and 0x81.
- R3: If a byte is accepted on clock edge E, its first symbol is presented after edge E+SYM_DIV, and the remaining three follow SYM_DIV clocks apart. Each `out_valid` strobe lasts one cycle.
- R4: `in_ready` is high when the block is idle. After an accepted byte it is low until the cycle in which the last pair of that byte is launched.
- R5: A byte offered back to back starts its first symbol exactly SYM_DIV clocks after the previous byte's last symbol.
- R6: Whenever `out_valid` is low, `out_i` and `out_q` are zero.
- R7: A synchronous active-high reset drops any byte in progress, holds `out_valid` low with I and Q at zero, and leaves `in_ready` high.
- R8: An `in_valid` offer that is withdrawn while `in_ready` is low is ignored and produces no symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Byte to be mapped |
| out_valid | output | 1 | One-cycle symbol strobe |
| out_i | output | SAMPLE_W | In-phase sample, two's complement |
| out_q | output | SAMPLE_W | Quadrature sample, two's complement |

## Verification
A pair pointer that slips or a shift in the wrong direction shows up within one symbol as a wrong I/Q level, or as the pairs of a byte in the wrong order. A divider or busy flag that is off by one shows up at the next strobe as a wrong spacing or latency. It can also show up when the next byte is handed over, as a gap, an overlap or a missing symbol. A stale busy state after reset appears as a strobe that nothing expected, or as `in_ready` held low.

// File: rtl/qpsk_pair_mapper.sv
module qpsk_pair_mapper #(
  parameter int SYM_DIV  = 4,
  parameter int SAMPLE_W = 8,
  parameter int AMP      = 127
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q
);
  localparam int CW = (SYM_DIV > 1) ? $clog2(SYM_DIV) : 1;
  localparam logic signed [SAMPLE_W-1:0] POS = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] NEG = SAMPLE_W'(-AMP);

  logic          busy;
  logic [7:0]    sh;
  logic [1:0]    idx;
  logic [CW-1:0] cnt;
  logic          emit, last, in_fire;

  assign emit     = busy && (cnt == CW'(SYM_DIV - 1));
  assign last     = emit && (idx == 2'd3);
  assign in_ready = !busy || last;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sh        <= '0;
      idx       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= emit;
      out_i     <= emit ? (sh[7] ? NEG : POS) : '0;
      out_q     <= emit ? (sh[6] ? NEG : POS) : '0;
      if (in_fire) begin
        busy <= 1'b1;
        sh   <= in_data;
        idx  <= '0;
        cnt  <= '0;
      end else if (emit) begin
        sh  <= {sh[5:0], 2'b00};
        idx <= idx + 2'd1;
        cnt <= '0;
        if (last) busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_i == '0 && out_q == '0));

  p_levels_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_i == POS || out_i == NEG) && (out_q == POS || out_q == NEG)));

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && out_i == '0 && out_q == '0));

  p_accept_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  generate
    if (SYM_DIV > 1) begin : g_pulse
      p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    end
  endgenerate
endmodule

// File: tb/qpsk_pair_mapper_bench.sv
module qpsk_pair_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [7:0] out_i, out_q;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit have_prev = 0;
  bit gap_chk = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  qpsk_pair_mapper #(.SYM_DIV(SYM_DIV), .SAMPLE_W(8), .AMP(127)) u_qpsk_pair_mapper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] p;
      p = b[7-2*k -: 2];
      exp_q.push_back({(p[1] ? 8'h81 : 8'h7F), (p[0] ? 8'h81 : 8'h7F)});
    end
  endtask

  task automatic send(input logic [7:0] b);
    push_byte(b);
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    check(!in_ready, "R4 ready low after accept", in_ready, 0);
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected symbol", {out_i, out_q}, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check({out_i, out_q} == e, "R1/R2 symbol value", {out_i, out_q}, e);
        end
        if (gap_chk && have_prev)
          check(cyc - last_cyc == SYM_DIV, "R3/R5 symbol spacing", cyc - last_cyc, SYM_DIV);
        have_prev = 1;
        last_cyc = cyc;
      end else begin
        check(out_i == 0 && out_q == 0, "R6 zero when idle", {out_i, out_q}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    check(!out_valid && out_i == 0 && out_q == 0, "R7 reset outputs", {out_valid, out_i, out_q}, 0);
    check(in_ready, "R7 ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready, "R4 ready when idle", in_ready, 1);

    // single byte: all four points, order and latency
    send(8'h1B);
    in_valid = 1'b0;
    acc = cyc;
    while (!out_valid) @(negedge clk);
    check(cyc - acc == SYM_DIV, "R3 first symbol latency", cyc - acc, SYM_DIV);
    gap_chk = 1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * SYM_DIV) @(negedge clk);
    gap_chk = 0;
    have_prev = 0;

    // back-to-back stream
    gap_chk = 1;
    send(8'hE4);
    send(8'h72);
    send(8'h00);
    send(8'hFF);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * SYM_DIV) @(negedge clk);
    gap_chk = 0;
    have_prev = 0;
    check(in_ready, "R4 ready after stream", in_ready, 1);

    // R8: offer withdrawn while busy
    send(8'h9C);
    in_data = 8'h33;
    repeat (2) @(negedge clk);
    check(!in_ready, "R8 busy during offer", in_ready, 0);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6 * SYM_DIV) @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, "R8 no extra symbols", exp_q.size(), 0);

    // R7: reset mid-byte
    send(8'hA5);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    @(negedge clk);
    check(!out_valid && in_ready, "R7 mid-byte reset", {out_valid, in_ready}, 1);
    rst = 1'b0;
    repeat (6 * SYM_DIV) @(negedge clk);
    check(in_ready && !out_valid, "R7 byte dropped", {out_valid, in_ready}, 1);

    // recovery after reset
    send(8'h4E);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * SYM_DIV) @(negedge clk);
    check(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule